// File: doc/BRIEF.md
# Sleep Pin Power Mode Decoder

This block decodes an active-low power control pin into one of three operating modes: active, duty-cycled low-power, or sleep. It classifies each low pulse on the pin by its width, which is measured in microsecond ticks taken from a clock prescaler. A low level held long enough selects sleep. A qualifying pair of medium-width pulses, separated by a gap inside a fixed window, selects low-power mode. Any pulse width outside the recognised bands is dropped.

In low-power mode the block cycles the sensing front end. The front end stays off for an idle interval, then comes on for a short wake window, and this repeats. An external rotation-detected input shortens the following idle interval when it is seen during a wake window. The front end is always enabled in active mode and always off in sleep. A ready flag shows that the outputs have settled. It rises a power-up delay after reset release, and a shorter settling delay after every return to active mode.

Top module: `sleep_mode_decoder`

## Requirements
- R1: Mode encoding on `mode_o`: 2'b00 active, 2'b01 low-power, 2'b10 sleep; 2'b11 never appears. After reset the mode is active, `fe_en_o` is 1 and `ready_o` is 0.
- R2: `ready_o` rises PWRUP_US µs (default 85) after reset release, within ±3 µs.
- R3: When the synchronised pin has been low for SLEEP_US µs (default 1100), the mode becomes sleep while the pin is still low, and `fe_en_o` and `ready_o` are 0. This happens from active or from low-power mode.
- R4: A rising edge on the pin while in sleep or low-power mode returns the block to active mode. `ready_o` stays 0 for SETTLE_US µs (default 50) after that edge, within ±3 µs, and is 1 afterwards.
- R5: In active mode, two low pulses that are each LP_MIN_US to LP_MAX_US wide (default 125 to 400), separated by a high gap of GAP_MIN_US to GAP_MAX_US (default 25 to 400), select low-power mode at the end of the second pulse. The last two pulses form the pair.
- R6: A gap longer than GAP_MAX_US, or shorter than GAP_MIN_US, abandons the pair, and the mode stays active.
- R7: A low pulse shorter than LP_MIN_US, or between LP_MAX_US and SLEEP_US, is ignored: the mode and `ready_o` are unchanged. Such a pulse also clears any pending first pulse of a pair.
- R8: In low-power mode with no rotation seen, `fe_en_o` is 0 for IDLE_US µs (default 25000), then 1 for WAKE_US µs (default 50), and the cycle repeats, starting with an idle interval at entry.
- R9: If `rot_det_i` is 1 during a wake window, the next idle interval lasts ROT_IDLE_US µs (default 2500) instead of IDLE_US.
- R10: In active mode `fe_en_o` is 1, including during low pulses. Outside active mode `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_ni | input | 1 | Asynchronous active-low power control pin |
| rot_det_i | input | 1 | Rotation detected by the front end |
| mode_o | output | 2 | Current mode (00 active, 01 low-power, 10 sleep) |
| fe_en_o | output | 1 | Front-end power enable |
| ready_o | output | 1 | Outputs settled |

## Verification
The bench builds the block with CLK_MHZ=2, so one microsecond is two cycles of the 200 MHz clock. This lets the real 1100 µs sleep threshold and the 125/400/25 µs pulse and gap bands be used unchanged. The low-power idle, rotation idle and wake intervals are reduced to 300, 100 and 20 µs. With those values, several complete front-end duty cycles and the shortened rotation interval fit in a short run. Random pulse pairs are drawn from classes kept a few microseconds clear of each band edge, and directed pulses sit close to the edges.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_LP     = 2'b01,
    MODE_SLEEP  = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int CLK_MHZ = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_MHZ <= 1) begin : g_direct
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni;
      assign tick_o   = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(CLK_MHZ);
      localparam logic [W-1:0] LAST = W'(CLK_MHZ - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pm_pin_sync.sv
module pm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/pm_pulse_meter.sv
module pm_pulse_meter #(
  parameter int LP_MIN_US  = 125,
  parameter int LP_MAX_US  = 400,
  parameter int SLEEP_US   = 1100,
  parameter int GAP_MIN_US = 25,
  parameter int GAP_MAX_US = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic lp_req_o,
  output logic sleep_req_o
);
  localparam int LW = $clog2(SLEEP_US + 1);
  localparam int GW = $clog2(GAP_MAX_US + 2);
  localparam logic [LW-1:0] L_MIN   = LW'(LP_MIN_US);
  localparam logic [LW-1:0] L_MAX   = LW'(LP_MAX_US);
  localparam logic [LW-1:0] L_SLEEP = LW'(SLEEP_US);
  localparam logic [LW-1:0] L_HIT   = LW'(SLEEP_US - 1);
  localparam logic [GW-1:0] G_MIN   = GW'(GAP_MIN_US);
  localparam logic [GW-1:0] G_MAX   = GW'(GAP_MAX_US);
  localparam logic [GW-1:0] G_SAT   = GW'(GAP_MAX_US + 1);

  logic [LW-1:0] low_cnt_q;
  logic [GW-1:0] gap_cnt_q;
  logic          armed_q;
  logic          width_ok, gap_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          low_cnt_q <= '0;
    else if (fall_i)                                      low_cnt_q <= '0;
    else if (!lvl_i && tick_i && low_cnt_q != L_SLEEP)    low_cnt_q <= low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          gap_cnt_q <= '0;
    else if (rise_i)                                      gap_cnt_q <= '0;
    else if (lvl_i && tick_i && gap_cnt_q != G_SAT)       gap_cnt_q <= gap_cnt_q + 1'b1;
  end

  assign width_ok = (low_cnt_q >= L_MIN) && (low_cnt_q <= L_MAX);
  assign gap_ok   = (gap_cnt_q >= G_MIN) && (gap_cnt_q <= G_MAX);

  // armed_q: a qualifying first pulse is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (fall_i) armed_q <= armed_q & gap_ok;
    else if (rise_i) armed_q <= width_ok & ~armed_q;
  end

  assign lp_req_o    = rise_i & width_ok & armed_q;
  assign sleep_req_o = ~lvl_i & ~fall_i & tick_i & (low_cnt_q == L_HIT);
endmodule

// File: rtl/pm_lp_timer.sv
module pm_lp_timer #(
  parameter int IDLE_US     = 25000,
  parameter int ROT_IDLE_US = 2500,
  parameter int WAKE_US     = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic rot_i,
  output logic on_o
);
  localparam int MAXV = (IDLE_US > ROT_IDLE_US) ?
                        ((IDLE_US > WAKE_US) ? IDLE_US : WAKE_US) :
                        ((ROT_IDLE_US > WAKE_US) ? ROT_IDLE_US : WAKE_US);
  localparam int TW = $clog2(MAXV + 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(IDLE_US - 1);
  localparam logic [TW-1:0] ROT_LAST  = TW'(ROT_IDLE_US - 1);
  localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_US - 1);

  logic [TW-1:0] cnt_q;
  logic          on_q, rot_flag_q, rot_seen_q;
  logic [TW-1:0] idle_last;

  assign idle_last = rot_seen_q ? ROT_LAST : IDLE_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; on_q <= 1'b0; rot_flag_q <= 1'b0; rot_seen_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0; on_q <= 1'b0; rot_flag_q <= 1'b0; rot_seen_q <= 1'b0;
    end else if (!on_q) begin
      if (tick_i) begin
        if (cnt_q == idle_last) begin
          on_q  <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin
      if (rot_i) rot_flag_q <= 1'b1;
      if (tick_i) begin
        if (cnt_q == WAKE_LAST) begin
          on_q       <= 1'b0;
          cnt_q      <= '0;
          rot_seen_q <= rot_flag_q | rot_i;
          rot_flag_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/sleep_mode_decoder.sv
module sleep_mode_decoder
  import pm_pkg::*;
#(
  parameter int CLK_MHZ     = 20,
  parameter int LP_MIN_US   = 125,
  parameter int LP_MAX_US   = 400,
  parameter int SLEEP_US    = 1100,
  parameter int GAP_MIN_US  = 25,
  parameter int GAP_MAX_US  = 400,
  parameter int SETTLE_US   = 50,
  parameter int PWRUP_US    = 85,
  parameter int IDLE_US     = 25000,
  parameter int ROT_IDLE_US = 2500,
  parameter int WAKE_US     = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_ni,
  input  logic       rot_det_i,
  output logic [1:0] mode_o,
  output logic       fe_en_o,
  output logic       ready_o
);
  localparam int SMAX = (PWRUP_US > SETTLE_US) ? PWRUP_US : SETTLE_US;
  localparam int SW   = $clog2(SMAX + 1);
  localparam logic [SW-1:0] S_PWRUP  = SW'(PWRUP_US);
  localparam logic [SW-1:0] S_SETTLE = SW'(SETTLE_US);

  logic tick, pin_lvl, pin_rise, pin_fall;
  logic lp_req, sleep_req, lp_on;
  logic settle_load;
  logic [SW-1:0] settle_q;
  pm_mode_e mode_q, mode_d;

  pm_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  pm_pin_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sleep_ni),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  pm_pulse_meter #(
    .LP_MIN_US(LP_MIN_US), .LP_MAX_US(LP_MAX_US), .SLEEP_US(SLEEP_US),
    .GAP_MIN_US(GAP_MIN_US), .GAP_MAX_US(GAP_MAX_US)
  ) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .lvl_i(pin_lvl),
    .rise_i(pin_rise), .fall_i(pin_fall),
    .lp_req_o(lp_req), .sleep_req_o(sleep_req)
  );

  pm_lp_timer #(
    .IDLE_US(IDLE_US), .ROT_IDLE_US(ROT_IDLE_US), .WAKE_US(WAKE_US)
  ) u_lp_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode_q == MODE_LP),
    .tick_i(tick), .rot_i(rot_det_i), .on_o(lp_on)
  );

  always_comb begin
    mode_d      = mode_q;
    settle_load = 1'b0;
    unique case (mode_q)
      MODE_ACTIVE: begin
        if (sleep_req)   mode_d = MODE_SLEEP;
        else if (lp_req) mode_d = MODE_LP;
      end
      MODE_LP: begin
        if (sleep_req) mode_d = MODE_SLEEP;
        else if (pin_rise) begin
          mode_d      = MODE_ACTIVE;
          settle_load = 1'b1;
        end
      end
      MODE_SLEEP: begin
        if (pin_rise) begin
          mode_d      = MODE_ACTIVE;
          settle_load = 1'b1;
        end
      end
      default: mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ACTIVE;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     settle_q <= S_PWRUP;
    else if (settle_load)            settle_q <= S_SETTLE;
    else if (tick && settle_q != '0) settle_q <= settle_q - 1'b1;
  end

  always_comb begin
    unique case (mode_q)
      MODE_ACTIVE: fe_en_o = 1'b1;
      MODE_LP:     fe_en_o = lp_on;
      default:     fe_en_o = 1'b0;
    endcase
  end

  assign mode_o  = mode_q;
  assign ready_o = (mode_q == MODE_ACTIVE) && (settle_q == '0);
endmodule

// File: rtl/pm_decoder_chk.sv
module pm_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       fe_en_i,
  input logic       ready_i,
  input logic       pin_lvl_i,
  input logic       pin_rise_i
);
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'b11);  // R1

  AST_SLEEP_FE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (!fe_en_i && !ready_i));  // R3

  AST_SLEEP_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && $past(mode_i) != 2'b10) |-> !$past(pin_lvl_i));  // R3

  AST_WAKE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00 && pin_rise_i) |=> (mode_i == 2'b00 && !ready_i));  // R4

  AST_LP_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && $past(mode_i) != 2'b01) |-> $past(pin_rise_i));  // R5

  AST_ACTIVE_FE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> fe_en_i);  // R10

  AST_READY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (mode_i == 2'b00));  // R10
endmodule

bind sleep_mode_decoder pm_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_o), .fe_en_i(fe_en_o),
  .ready_i(ready_o), .pin_lvl_i(pin_lvl), .pin_rise_i(pin_rise)
);

// File: tb/sleep_mode_decoder_bench.sv
`timescale 1ns/1ps
module sleep_mode_decoder_bench;
  localparam int CLK_MHZ = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       rot = 1'b0;
  logic [1:0] mode;
  logic       fe, rdy;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_mode_decoder #(
    .CLK_MHZ(CLK_MHZ), .LP_MIN_US(125), .LP_MAX_US(400), .SLEEP_US(1100),
    .GAP_MIN_US(25), .GAP_MAX_US(400), .SETTLE_US(50), .PWRUP_US(85),
    .IDLE_US(300), .ROT_IDLE_US(100), .WAKE_US(20)
  ) u_sleep_mode_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(pin_n), .rot_det_i(rot),
    .mode_o(mode), .fe_en_o(fe), .ready_o(rdy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CLK_MHZ) @(negedge clk);
  endtask

  task automatic low_pulse(input int w);
    pin_n = 1'b0;
    wait_us(w);
    pin_n = 1'b1;
  endtask

  function automatic bit width_qual(input int w);
    return (w >= 125) && (w <= 400);
  endfunction

  function automatic bit expect_lp(input int w1, input int g, input int w2);
    return width_qual(w1) && width_qual(w2) && (g >= 25) && (g <= 400);
  endfunction

  function automatic int pick(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  function automatic int pick_width();
    int c = int'($urandom % 4);
    if (c == 0) return pick(5, 115);
    if (c == 3) return pick(410, 700);
    return pick(135, 390);
  endfunction

  function automatic int pick_gap();
    int c = int'($urandom % 4);
    if (c == 0) return pick(3, 18);
    if (c == 3) return pick(410, 550);
    return pick(35, 390);
  endfunction

  task automatic exit_lp(input string req);
    low_pulse(50);
    wait_us(4);
    check({req, " exit to active"}, mode, 0);
    wait_us(56);
  endtask

  initial begin
    int w1, g, w2;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset mode", mode, 0);
    check("R1 reset fe_en", fe, 1);
    check("R1 reset ready", rdy, 0);
    wait_us(80);
    check("R2 ready low before power-up delay", rdy, 0);
    wait_us(10);
    check("R2 ready high after power-up delay", rdy, 1);

    // sleep from active
    pin_n = 1'b0;
    wait_us(1095);
    check("R3 still active below sleep width", mode, 0);
    check("R10 fe_en on during low pulse", fe, 1);
    wait_us(11);
    check("R3 sleep mode", mode, 2);
    check("R3 fe_en off in sleep", fe, 0);
    check("R3 ready low in sleep", rdy, 0);
    wait_us(100);
    pin_n = 1'b1;
    wait_us(4);
    check("R4 wake from sleep", mode, 0);
    check("R4 ready low after wake", rdy, 0);
    wait_us(41);
    check("R4 ready low within settle", rdy, 0);
    wait_us(12);
    check("R4 ready high after settle", rdy, 1);

    // low-power entry and duty cycle
    wait_us(500);
    low_pulse(200); wait_us(100); low_pulse(200);
    wait_us(4);
    check("R5 low-power entry", mode, 1);
    check("R10 ready low in low-power", rdy, 0);
    check("R8 front end off at entry", fe, 0);
    wait_us(286);
    check("R8 off before idle ends", fe, 0);
    wait_us(22);
    check("R8 on in wake window", fe, 1);
    wait_us(18);
    check("R8 off after wake window", fe, 0);
    wait_us(280);
    check("R8 off in second idle", fe, 0);
    wait_us(5);
    rot = 1'b1;
    wait_us(17);
    check("R8 second wake window", fe, 1);
    wait_us(18);
    rot = 1'b0;
    wait_us(102);
    check("R9 early wake after rotation", fe, 1);
    wait_us(18);
    check("R9 early wake ends", fe, 0);
    check("R5 still low-power", mode, 1);
    low_pulse(50);
    wait_us(4);
    check("R4 wake from low-power", mode, 0);
    wait_us(53);
    check("R4 ready after low-power exit", rdy, 1);

    // gap too long
    wait_us(500);
    low_pulse(200); wait_us(500); low_pulse(200);
    wait_us(4);
    check("R6 long gap stays active", mode, 0);
    check("R6 long gap ready kept", rdy, 1);

    // gap too short
    wait_us(500);
    low_pulse(200); wait_us(10); low_pulse(200);
    wait_us(4);
    check("R6 short gap stays active", mode, 0);

    // short first pulse ignored; last two pulses form the pair
    wait_us(500);
    low_pulse(100); wait_us(100); low_pulse(200);
    wait_us(4);
    check("R7 short pulse ignored", mode, 0);
    wait_us(96);
    low_pulse(200);
    wait_us(4);
    check("R5 pair from last two pulses", mode, 1);
    exit_lp("R4");

    // mid-width pulse ignored and clears a pending pulse
    wait_us(500);
    low_pulse(200); wait_us(100);
    pin_n = 1'b0;
    wait_us(350);
    check("R7 ready kept during mid pulse", rdy, 1);
    check("R10 fe_en on during mid pulse", fe, 1);
    wait_us(350);
    pin_n = 1'b1;
    wait_us(4);
    check("R7 mid pulse ignored", mode, 0);
    check("R7 ready unchanged after mid pulse", rdy, 1);
    wait_us(96);
    low_pulse(200);
    wait_us(4);
    check("R7 mid pulse cleared pending pair", mode, 0);

    // band edges
    wait_us(500);
    low_pulse(132); wait_us(30); low_pulse(390);
    wait_us(4);
    check("R5 near-edge widths and short gap", mode, 1);
    exit_lp("R4");
    wait_us(500);
    low_pulse(200); wait_us(390); low_pulse(200);
    wait_us(4);
    check("R5 near-edge long gap", mode, 1);
    exit_lp("R4");

    // sleep from low-power
    wait_us(500);
    low_pulse(200); wait_us(100); low_pulse(200);
    wait_us(4);
    check("R5 low-power before sleep", mode, 1);
    pin_n = 1'b0;
    wait_us(1106);
    check("R3 sleep from low-power", mode, 2);
    pin_n = 1'b1;
    wait_us(4);
    check("R4 wake after sleep from low-power", mode, 0);
    wait_us(500);

    // random pairs
    for (int i = 0; i < 12; i++) begin
      w1 = pick_width(); g = pick_gap(); w2 = pick_width();
      low_pulse(w1); wait_us(g); low_pulse(w2);
      wait_us(4);
      check($sformatf("R5 R6 R7 random pair %0d/%0d/%0d mode", w1, g, w2),
            mode, expect_lp(w1, g, w2) ? 1 : 0);
      check($sformatf("R10 random pair %0d/%0d/%0d ready", w1, g, w2),
            rdy, expect_lp(w1, g, w2) ? 0 : 1);
      if (expect_lp(w1, g, w2)) exit_lp("R4");
      wait_us(500);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule